// File: doc/BRIEF.md
# Three-Symbol Constant-Weight Checksum Encoder

This block turns a 6-bit data word into a 12-wire code block built from three 4-wire symbols. Every symbol has exactly two of its four wires high. The six weight-two words are grouped into three pairs. Within each pair the two words differ in all four positions. Each pair is named by a base-3 group number.

Two of the symbols carry data group numbers taken from the upper three input bits. The third symbol carries a check group number, which is the mod-3 sum of the other two. A receiver can therefore tell which group a corrupted symbol should have belonged to. Inside that group, a minimum-distance choice between the two words recovers one flipped wire. The lower three input bits choose which word of its group each symbol uses, so they ride along at no extra wire cost.

A word is accepted when its qualifier is high. The encoded block appears on a registered output one clock later, together with its own valid flag.

Top module: `hecc_encoder`

## Requirements
- R1: Whenever `out_vld` is high, each of the three 4-bit symbols in `out_word` has exactly two bits set.
- R2: The upper input bits `in_data[5:3]`, read as an unsigned value v, give data group v/3 in symbol A (`out_word[11:8]`) and data group v mod 3 in symbol B (`out_word[7:4]`). Group pair (2,2) never appears.
- R3: The check symbol in `out_word[3:0]` belongs to group (A + B) mod 3.
- R4: Group 0 uses words 0011 and 1100, group 1 uses 0101 and 1010, and group 2 uses 0110 and 1001. The first word listed for each group is member 0 and the second is member 1.
- R5: `in_data[2]` selects the member of symbol A, `in_data[1]` the member of symbol B, and `in_data[0]` the member of the check symbol.
- R6: `out_vld` equals the value `in_vld` had on the previous rising clock edge. The block accepted in that cycle appears on `out_word` in the same cycle as `out_vld`.
- R7: A synchronous active-high `rst` clears `out_word` to zero and `out_vld` to 0 on the next rising edge. This takes priority over a word presented with `in_vld` high in the same cycle.
- R8: While `in_vld` is low, `in_data` has no effect: `out_word` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Qualifies `in_data` for this cycle |
| in_data | input | 6 | Data word: [5:3] group pair, [2:0] member choices |
| out_vld | output | 1 | Registered valid flag for `out_word` |
| out_word | output | 12 | Encoded block: symbol A [11:8], symbol B [7:4], check [3:0] |

## Verification
All internal state reaches the ports one edge after the word is accepted, so any fault shows up on the very next cycle. A wrong split of the upper bits, or a wrong mod-3 sum, makes the three decoded group numbers fail the checksum relation, or produces the forbidden (2,2) pair. A wrong member table makes a symbol lose its weight of two, or swaps it for its complement, which the per-vector expected values expose. A loading fault in the output register shows up either as `out_word` changing during an idle cycle or as `out_vld` being out of step with `in_vld`.

// File: rtl/hecc_pkg.sv
package hecc_pkg;

  localparam int DATA_W = 6;
  localparam int HI_W   = 3;
  localparam int LO_W   = DATA_W - HI_W;
  localparam int SYM_W  = 4;
  localparam int NSYM   = 3;
  localparam int OUT_W  = SYM_W * NSYM;
  localparam int RADIX  = 3;
  localparam int GRP_W  = 2;

  typedef logic [GRP_W-1:0] grp_t;
  typedef logic [SYM_W-1:0] sym_t;
  typedef logic [HI_W-1:0]  hi_t;

  typedef struct packed {
    grp_t first;
    grp_t second;
  } grp_pair_t;

  // Radix-3 split of the upper field: quotient and remainder.
  function automatic grp_pair_t split_hi(input hi_t v);
    grp_pair_t r;
    logic [HI_W-1:0] q;
    q = v / HI_W'(RADIX);
    r.first  = grp_t'(q);
    r.second = grp_t'(v - q * HI_W'(RADIX));
    return r;
  endfunction

  // Modular addition of two group numbers.
  function automatic grp_t add_mod3(input grp_t a, input grp_t b);
    logic [GRP_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= (GRP_W+1)'(RADIX)) s = s - (GRP_W+1)'(RADIX);
    return grp_t'(s);
  endfunction

  // Member 0 of each group; member 1 is its bitwise complement.
  function automatic sym_t base_word(input grp_t g);
    case (g)
      2'd0:    return 4'b0011;
      2'd1:    return 4'b0101;
      2'd2:    return 4'b0110;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic sym_t pick_word(input grp_t g, input logic member);
    sym_t w;
    w = base_word(g);
    return member ? ~w : w;
  endfunction

endpackage

// File: rtl/hecc_group_split.sv
module hecc_group_split
  import hecc_pkg::*;
(
  input  hi_t  hi_bits,
  output grp_t grp_a,
  output grp_t grp_b
);
  grp_pair_t pair;

  always_comb begin
    pair  = split_hi(hi_bits);
    grp_a = pair.first;
    grp_b = pair.second;
  end
endmodule

// File: rtl/hecc_check_sum.sv
module hecc_check_sum
  import hecc_pkg::*;
(
  input  grp_t grp_a,
  input  grp_t grp_b,
  output grp_t grp_chk
);
  always_comb grp_chk = add_mod3(grp_a, grp_b);
endmodule

// File: rtl/hecc_member_map.sv
module hecc_member_map
  import hecc_pkg::*;
(
  input  grp_t grp,
  input  logic member,
  output sym_t word
);
  always_comb word = pick_word(grp, member);
endmodule

// File: rtl/hecc_encoder.sv
module hecc_encoder
  import hecc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_vld,
  output logic [OUT_W-1:0]  out_word
);

  // Named internal events, visible to the bound checker.
  grp_t grp_a;
  grp_t grp_b;
  grp_t grp_chk;
  logic load_en;
  logic [OUT_W-1:0] next_word;

  grp_t grp_vec [NSYM];

  hecc_group_split u_split (
    .hi_bits (in_data[DATA_W-1 -: HI_W]),
    .grp_a   (grp_a),
    .grp_b   (grp_b)
  );

  hecc_check_sum u_sum (
    .grp_a   (grp_a),
    .grp_b   (grp_b),
    .grp_chk (grp_chk)
  );

  assign grp_vec[0] = grp_a;
  assign grp_vec[1] = grp_b;
  assign grp_vec[2] = grp_chk;

  for (genvar i = 0; i < NSYM; i++) begin : g_sym
    sym_t w;
    hecc_member_map u_map (
      .grp    (grp_vec[i]),
      .member (in_data[LO_W-1-i]),
      .word   (w)
    );
    assign next_word[OUT_W-1-i*SYM_W -: SYM_W] = w;
  end

  assign load_en = in_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      out_word <= '0;
    end else begin
      out_vld <= in_vld;
      if (load_en) out_word <= next_word;
    end
  end

endmodule

// File: rtl/hecc_encoder_chk.sv
module hecc_encoder_chk
  import hecc_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              in_vld,
  input logic [OUT_W-1:0]  out_word,
  input logic              out_vld,
  input grp_t              grp_a,
  input grp_t              grp_b,
  input grp_t              grp_chk
);

  function automatic grp_t group_of(input sym_t w);
    if (w == 4'b0011 || w == 4'b1100) return 2'd0;
    if (w == 4'b0101 || w == 4'b1010) return 2'd1;
    if (w == 4'b0110 || w == 4'b1001) return 2'd2;
    return 2'd3;
  endfunction

  grp_t dec_a, dec_b, dec_c;
  logic [GRP_W:0] dec_sum;
  assign dec_a   = group_of(out_word[11:8]);
  assign dec_b   = group_of(out_word[7:4]);
  assign dec_c   = group_of(out_word[3:0]);
  assign dec_sum = {1'b0, dec_a} + {1'b0, dec_b};

  // R1
  weight_two_chk: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> ($countones(out_word[11:8]) == 2 && $countones(out_word[7:4]) == 2
                 && $countones(out_word[3:0]) == 2));

  // R2
  no_pair22_chk: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> !(dec_a == 2'd2 && dec_b == 2'd2));

  // R3
  checksum_chk: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> ((dec_sum % 3) == {1'b0, dec_c}));

  // R3
  groups_carried_chk: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> (dec_a == $past(grp_a) && dec_b == $past(grp_b) && dec_c == $past(grp_chk)));

  // R6
  vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_vld);

  // R6
  vld_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !out_vld);

  // R8
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> $stable(out_word));

endmodule

bind hecc_encoder hecc_encoder_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_vld   (in_vld),
  .out_word (out_word),
  .out_vld  (out_vld),
  .grp_a    (grp_a),
  .grp_b    (grp_b),
  .grp_chk  (grp_chk)
);

// File: tb/hecc_encoder_bench.sv
`timescale 1ns/1ps
module hecc_encoder_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_vld;
  logic [5:0]  in_data;
  logic        out_vld;
  logic [11:0] out_word;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  hecc_encoder u_hecc_encoder (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_data(in_data),
    .out_vld(out_vld), .out_word(out_word)
  );

  // {input, expected block}, worked out by hand from R2..R5.
  localparam logic [17:0] VEC [13] = '{
    {6'b000000, 12'h333}, {6'b111101, 12'h95C}, {6'b111111, 12'h9AC},
    {6'b000111, 12'hCCC}, {6'b001000, 12'h355}, {6'b010010, 12'h396},
    {6'b011001, 12'h53A}, {6'b100100, 12'hA56}, {6'b101011, 12'h59C},
    {6'b110110, 12'h9C6}, {6'b110001, 12'h639}, {6'b111000, 12'h653},
    {6'b100011, 12'h5A9}
  };

  // Word table indexed by group*2 + member (R4).
  localparam logic [3:0] WTAB [6] = '{4'h3, 4'hC, 4'h5, 4'hA, 4'h6, 4'h9};

  function automatic logic [11:0] model(input logic [5:0] d);
    int v, ga, gb, gc;
    v  = int'(d[5:3]);
    ga = 0;
    while ((ga + 1) * 3 <= v) ga++;
    gb = v - ga * 3;
    gc = ga + gb;
    if (gc >= 3) gc -= 3;
    return {WTAB[ga*2 + int'(d[2])], WTAB[gb*2 + int'(d[1])], WTAB[gc*2 + int'(d[0])]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [5:0] d);
    @(negedge clk);
    in_vld  = 1'b1;
    in_data = d;
    @(negedge clk);
  endtask

  function automatic int grp_of(input logic [3:0] w);
    for (int k = 0; k < 6; k++) if (WTAB[k] == w) return k / 2;
    return 9;
  endfunction

  initial begin
    rst = 1'b1; in_vld = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    // R7: reset state
    check("R7 reset vld", 32'(out_vld), 0);
    check("R7 reset word", 32'(out_word), 0);
    rst = 1'b0;

    // Table walk: R2 R4 R5 R6
    for (int i = 0; i < 13; i++) begin
      send(VEC[i][17:12]);
      check("R2/R4/R5 table", 32'(out_word), 32'(VEC[i][11:0]));
      check("R6 vld", 32'(out_vld), 1);
    end

    // Exhaustive: R1 weight, R3 checksum, full model
    for (int d = 0; d < 64; d++) begin
      send(6'(d));
      check("R1 weight", 32'($countones(out_word[11:8]) == 2 && $countones(out_word[7:4]) == 2
                              && $countones(out_word[3:0]) == 2), 1);
      check("R3 checksum", 32'(grp_of(out_word[3:0])),
            32'((grp_of(out_word[11:8]) + grp_of(out_word[7:4])) % 3));
      check("R2 model", 32'(out_word), 32'(model(6'(d))));
    end

    // R8: idle cycles ignore in_data
    send(6'b110110);
    @(negedge clk);
    in_vld = 1'b0; in_data = 6'b000111;
    @(negedge clk);
    check("R8 hold word", 32'(out_word), 32'h9C6);
    check("R6 vld low", 32'(out_vld), 0);
    in_data = 6'b101010;
    @(negedge clk);
    check("R8 hold again", 32'(out_word), 32'h9C6);

    // R7: reset wins over a valid word
    in_vld = 1'b1; in_data = 6'b111111; rst = 1'b1;
    @(negedge clk);
    check("R7 priority vld", 32'(out_vld), 0);
    check("R7 priority word", 32'(out_word), 0);
    rst = 1'b0; in_vld = 1'b0;
    @(negedge clk);
    check("R6 after reset", 32'(out_vld), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule